// File: doc/BRIEF.md
# Wavefront Quarter-Step Sequencer

This block runs one vector instruction for a 64-thread wavefront on a datapath that has only 16 lanes. After an operation is accepted, it walks the wavefront in four quarters: threads 0 to 15, then 16 to 31, then 32 to 47, then 48 to 63. For each quarter it drives a group select and a per-lane enable mask. An operation on a vector type has one to four components. These are split into separate scalar passes, and each component runs all four quarters before the next component starts. The lane arithmetic is modelled as a 32-bit wrapping add of two operand vectors. The operand vectors are supplied by the surrounding register file for the quarter currently selected.

Issue uses a valid/ready handshake. `iss_ready` is high only while the block is idle, and an operation transfers on a clock edge where both `iss_valid` and `iss_ready` are high. There is no queue, so an upstream scheduler must hold `iss_valid` until it sees `iss_ready`. The thread count that goes with each operation masks off threads at or above that count. Those threads are still stepped through, but their enables are low and their results are zero.

The `slot_steal` input lets a neighbouring wavefront take the issue slot before a component begins. In that case the component starts later, so an operation can take longer than four cycles per component. Once a quarter sequence has started, nothing interrupts it. `done` pulses for one cycle after the final quarter of the last component.

Top module: `wave_seq_top`

## Requirements
- R1: After reset, `iss_ready` is 1 and `busy`, `done` and `step_valid` are 0.
- R2: An operation is accepted on an edge where `iss_valid` and `iss_ready` are both 1. `busy` is 1 from the next cycle on. While `busy` is 1, `iss_ready` is 0 and changes on `iss_valid`, `iss_ncomp_m1` or `iss_tcount` have no effect on the running sequence.
- R3: Each component occupies exactly four step cycles, with `grp_sel` equal to 0, 1, 2 and 3 in consecutive cycles and `comp_sel` constant across them.
- R4: `iss_ncomp_m1` holds the component count minus one, so 0 to 3 means 1 to 4 components. Components run in the order `comp_sel` = 0 up to `iss_ncomp_m1`. Without slot steals, the 4*(`iss_ncomp_m1`+1) step cycles immediately follow the accept edge.
- R5: During a step, `lane_en[l]` is 1 exactly when 16*`grp_sel` + l is less than the latched `iss_tcount`. A count of 64 or more enables every lane, and a count of 0 enables none.
- R6: During a step, result lane l (bits 32l+31 down to 32l) equals (`opa` lane l + `opb` lane l) mod 2^32 when `lane_en[l]` is 1, and 0 otherwise.
- R7: In a cycle where `busy` is 1, the next quarter is 0 and `slot_steal` is 1, no step occurs: `step_valid` is 0 and the component waits, with no limit on the number of such cycles.
- R8: `slot_steal` asserted while quarters 1 to 3 of a component are due has no effect, and the quarter sequence continues without a gap.
- R9: `done` is 1 for exactly one cycle, the cycle after the last quarter of the last component. In that cycle `busy` is 0 and a new operation can be accepted.
- R10: While idle, `step_valid` is 0 and `lane_en` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Operation offered |
| iss_ready | output | 1 | Block idle, can accept |
| iss_ncomp_m1 | input | 2 | Component count minus one |
| iss_tcount | input | 7 | Active thread count of the wavefront |
| slot_steal | input | 1 | Another wave takes the slot before a component start |
| opa | input | 512 | Operand A, 16 lanes of 32 bits |
| opb | input | 512 | Operand B, 16 lanes of 32 bits |
| step_valid | output | 1 | A quarter executes this cycle |
| grp_sel | output | 2 | Thread quarter being executed |
| comp_sel | output | 2 | Component being executed |
| lane_en | output | 16 | Per-lane enable for this quarter |
| res | output | 512 | Masked per-lane sums |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 16 lanes, 64 threads, four components at most and 32-bit lanes. With these values all four quarter boundaries, the largest component count and the 32-bit wrap of a lane sum are within reach of short directed runs. A thread count of 37 ends partway through a quarter. Counts of 0 and 100 cover the all-off and clamped all-on masks. A steal pattern that hits both component starts and mid-component quarters separates the delayed case from the ignored case. Back-to-back issue in the `done` cycle exercises the handover from one operation to the next.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/wave_seq_ctrl.sv
module wave_seq_ctrl
  import wave_seq_pkg::*;
#(
  parameter int QUARTERS = 4,
  parameter int QW       = 2,
  parameter int CW       = 2,
  parameter int TW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [CW-1:0] iss_ncomp_m1,
  input  logic [TW-1:0] iss_tcount,
  input  logic          slot_steal,
  output logic          idle,
  output logic          step,
  output logic [QW-1:0] quarter,
  output logic [CW-1:0] comp,
  output logic [TW-1:0] tcnt,
  output logic          done
);
  localparam logic [QW-1:0] LAST_Q = QW'(QUARTERS - 1);

  run_state_e    state;
  logic [CW-1:0] last_comp;
  logic          stall;

  assign idle  = (state == ST_IDLE);
  assign stall = (state == ST_RUN) && (quarter == '0) && slot_steal;
  assign step  = (state == ST_RUN) && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      quarter   <= '0;
      comp      <= '0;
      last_comp <= '0;
      tcnt      <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (iss_valid) begin
          state     <= ST_RUN;
          quarter   <= '0;
          comp      <= '0;
          last_comp <= iss_ncomp_m1;
          tcnt      <= iss_tcount;
        end
      end else if (step) begin
        if (quarter == LAST_Q) begin
          quarter <= '0;
          if (comp == last_comp) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            comp <= comp + 1'b1;
          end
        end else begin
          quarter <= quarter + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wave_seq_mask.sv
module wave_seq_mask #(
  parameter int LANES = 16,
  parameter int QW    = 2,
  parameter int TW    = 7
) (
  input  logic             step,
  input  logic [QW-1:0]    quarter,
  input  logic [TW-1:0]    tcnt,
  output logic [LANES-1:0] en
);
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int IW   = QW + LW;
  localparam int CMPW = (TW > IW) ? TW : IW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IW-1:0] thread_idx;
    assign thread_idx = {quarter, LW'(l)};
    assign en[l] = step && (CMPW'(thread_idx) < CMPW'(tcnt));
  end
endmodule

// File: rtl/wave_seq_alu.sv
module wave_seq_alu #(
  parameter int LANES = 16,
  parameter int DW    = 32
) (
  input  logic [LANES-1:0]    en,
  input  logic [LANES*DW-1:0] a,
  input  logic [LANES*DW-1:0] b,
  output logic [LANES*DW-1:0] y
);
  for (genvar l = 0; l < LANES; l++) begin : g_add
    logic [DW-1:0] sum;
    assign sum = a[l*DW +: DW] + b[l*DW +: DW];
    assign y[l*DW +: DW] = en[l] ? sum : '0;
  end
endmodule

// File: rtl/wave_seq_top.sv
module wave_seq_top #(
  parameter int LANES    = 16,
  parameter int WAVE     = 64,
  parameter int DW       = 32,
  parameter int MAX_COMP = 4,
  localparam int QUARTERS = WAVE / LANES,
  localparam int QW       = (QUARTERS > 1) ? $clog2(QUARTERS) : 1,
  localparam int CW       = (MAX_COMP > 1) ? $clog2(MAX_COMP) : 1,
  localparam int TW       = $clog2(WAVE + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_valid,
  output logic                iss_ready,
  input  logic [CW-1:0]       iss_ncomp_m1,
  input  logic [TW-1:0]       iss_tcount,
  input  logic                slot_steal,
  input  logic [LANES*DW-1:0] opa,
  input  logic [LANES*DW-1:0] opb,
  output logic                step_valid,
  output logic [QW-1:0]       grp_sel,
  output logic [CW-1:0]       comp_sel,
  output logic [LANES-1:0]    lane_en,
  output logic [LANES*DW-1:0] res,
  output logic                busy,
  output logic                done
);
  logic          idle;
  logic          step;
  logic [TW-1:0] tcnt;

  wave_seq_ctrl #(
    .QUARTERS(QUARTERS), .QW(QW), .CW(CW), .TW(TW)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_valid    (iss_valid),
    .iss_ncomp_m1 (iss_ncomp_m1),
    .iss_tcount   (iss_tcount),
    .slot_steal   (slot_steal),
    .idle         (idle),
    .step         (step),
    .quarter      (grp_sel),
    .comp         (comp_sel),
    .tcnt         (tcnt),
    .done         (done)
  );

  wave_seq_mask #(
    .LANES(LANES), .QW(QW), .TW(TW)
  ) mask_i (
    .step    (step),
    .quarter (grp_sel),
    .tcnt    (tcnt),
    .en      (lane_en)
  );

  wave_seq_alu #(
    .LANES(LANES), .DW(DW)
  ) alu_i (
    .en (lane_en),
    .a  (opa),
    .b  (opb),
    .y  (res)
  );

  assign iss_ready  = idle;
  assign busy       = !idle;
  assign step_valid = step;
endmodule

// File: rtl/wave_seq_chk.sv
module wave_seq_chk #(
  parameter int LANES    = 16,
  parameter int QUARTERS = 4,
  parameter int QW       = 2,
  parameter int CW       = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_ready,
  input logic             slot_steal,
  input logic             step_valid,
  input logic [QW-1:0]    grp_sel,
  input logic [CW-1:0]    comp_sel,
  input logic [LANES-1:0] lane_en,
  input logic             busy,
  input logic             done
);
  localparam logic [QW-1:0] LAST_Q = QW'(QUARTERS - 1);

  AST_QUARTER_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && grp_sel != LAST_Q |=> step_valid && grp_sel == $past(grp_sel) + 1'b1 && comp_sel == $past(comp_sel)); // R3

  AST_STEAL_ONLY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step_valid |-> slot_steal && grp_sel == '0); // R7

  AST_MASK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> (lane_en & (lane_en + 1'b1)) == '0); // R5

  AST_MASK_TAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && $past(step_valid) && grp_sel != '0 && !(&$past(lane_en)) |-> lane_en == '0); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(step_valid) && $past(grp_sel) == LAST_Q); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> iss_ready && !busy); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ready |-> !step_valid && lane_en == '0); // R10
endmodule

bind wave_seq_top wave_seq_chk #(
  .LANES(LANES), .QUARTERS(QUARTERS), .QW(QW), .CW(CW)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_ready  (iss_ready),
  .slot_steal (slot_steal),
  .step_valid (step_valid),
  .grp_sel    (grp_sel),
  .comp_sel   (comp_sel),
  .lane_en    (lane_en),
  .busy       (busy),
  .done       (done)
);

// File: tb/wave_seq_top_tb_top.sv
`timescale 1ns/1ps
module wave_seq_top_tb_top;
  localparam int LANES = 16;
  localparam int DW    = 32;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                iss_valid = 1'b0;
  logic                iss_ready;
  logic [1:0]          iss_ncomp_m1 = '0;
  logic [6:0]          iss_tcount = '0;
  logic                slot_steal = 1'b0;
  logic [LANES*DW-1:0] opa = '0;
  logic [LANES*DW-1:0] opb = '0;
  logic                step_valid;
  logic [1:0]          grp_sel;
  logic [1:0]          comp_sel;
  logic [LANES-1:0]    lane_en;
  logic [LANES*DW-1:0] res;
  logic                busy;
  logic                done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wave_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_ncomp_m1(iss_ncomp_m1), .iss_tcount(iss_tcount), .slot_steal(slot_steal),
    .opa(opa), .opb(opb), .step_valid(step_valid), .grp_sel(grp_sel),
    .comp_sel(comp_sel), .lane_en(lane_en), .res(res), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string detail);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  task automatic drive_operands(input int k);
    for (int l = 0; l < LANES; l++) begin
      opa[l*DW +: DW] = 32'(k) * 32'h0101_0101 + 32'(l) * 32'h11;
      opb[l*DW +: DW] = 32'h100 + 32'(l);
    end
    opa[DW-1:0] = 32'hFFFF_FFF0 + 32'(k);
    opb[DW-1:0] = 32'h20;
  endtask

  // Starts at a negedge with the block idle; ends at the negedge of the done cycle.
  task automatic run_op(input logic [1:0] nm1, input int tc, input logic [31:0] steal_pat,
                        input bit hold_valid, input string tag);
    int q = 0;
    int c = 0;
    int k = 0;
    bit fin = 1'b0;
    logic [LANES-1:0] exp_en;
    logic [LANES*DW-1:0] exp_res;
    check(iss_ready === 1'b1, "R2", $sformatf("%s ready before issue got %b exp 1", tag, iss_ready));
    iss_valid = 1'b1;
    iss_ncomp_m1 = nm1;
    iss_tcount = 7'(tc);
    slot_steal = 1'b0;
    while (!fin && k < 32) begin
      @(posedge clk); #1;
      iss_valid = hold_valid;
      if (hold_valid) begin
        iss_ncomp_m1 = ~nm1;
        iss_tcount = 7'd5;
      end
      slot_steal = steal_pat[k];
      drive_operands(k);
      @(negedge clk);
      check(busy === 1'b1 && iss_ready === 1'b0 && done === 1'b0, "R2",
            $sformatf("%s cyc %0d busy/ready/done got %b%b%b exp 100", tag, k, busy, iss_ready, done));
      if (q == 0 && steal_pat[k]) begin
        check(step_valid === 1'b0, "R7",
              $sformatf("%s cyc %0d step_valid got %b exp 0", tag, k, step_valid));
      end else begin
        check(step_valid === 1'b1 && grp_sel === 2'(q) && comp_sel === 2'(c), "R3",
              $sformatf("%s cyc %0d R4/R8 step,grp,comp got %b,%0d,%0d exp 1,%0d,%0d",
                        tag, k, step_valid, grp_sel, comp_sel, q, c));
        for (int l = 0; l < LANES; l++) begin
          exp_en[l] = (q * LANES + l) < tc;
          exp_res[l*DW +: DW] = exp_en[l] ? opa[l*DW +: DW] + opb[l*DW +: DW] : '0;
        end
        check(lane_en === exp_en, "R5",
              $sformatf("%s cyc %0d lane_en got %h exp %h", tag, k, lane_en, exp_en));
        check(res === exp_res, "R6",
              $sformatf("%s cyc %0d res got %h exp %h", tag, k, res, exp_res));
        if (q == 3) begin
          q = 0;
          if (c == int'(nm1)) fin = 1'b1;
          else c++;
        end else begin
          q++;
        end
      end
      k++;
    end
    @(posedge clk); #1;
    iss_valid = 1'b0;
    slot_steal = 1'b0;
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0 && iss_ready === 1'b1 && step_valid === 1'b0, "R9",
          $sformatf("%s done/busy/ready/step got %b%b%b%b exp 1010", tag, done, busy, iss_ready, step_valid));
  endtask

  task automatic t_reset();
    check(iss_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && step_valid === 1'b0, "R1",
          $sformatf("reset ready/busy/done/step got %b%b%b%b exp 1000", iss_ready, busy, done, step_valid));
  endtask

  task automatic t_idle();
    drive_operands(3);
    slot_steal = 1'b1;
    @(negedge clk);
    check(step_valid === 1'b0 && lane_en === '0 && done === 1'b0, "R10",
          $sformatf("idle step/en/done got %b %h %b exp 0 0 0", step_valid, lane_en, done));
    slot_steal = 1'b0;
  endtask

  task automatic t_single_full();  run_op(2'd0, 64, 32'h0, 1'b0, "R4 single"); endtask
  task automatic t_vec2_partial(); run_op(2'd1, 37, 32'h0, 1'b0, "R5 vec2 tc37"); endtask
  task automatic t_zero_threads(); run_op(2'd0, 0, 32'h0, 1'b0, "R5 tc0"); endtask
  task automatic t_clamp();        run_op(2'd2, 100, 32'h0, 1'b0, "R5 tc100"); endtask
  // steals: cycle 0,1 (start of c0), cycles 3,4 (mid c0, R8), cycle 6 (start of c1)
  task automatic t_vec4_steal();   run_op(2'd3, 50, 32'h0000_005B, 1'b0, "R7 R8 vec4"); endtask
  task automatic t_busy_ignore();  run_op(2'd1, 20, 32'h0, 1'b1, "R2 hold"); endtask

  task automatic t_back_to_back();
    run_op(2'd0, 16, 32'h0, 1'b0, "R9 b2b first");
    run_op(2'd1, 63, 32'h0, 1'b0, "R9 b2b second");
    @(negedge clk);
    check(done === 1'b0, "R9", $sformatf("done after pulse got %b exp 0", done));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_single_full();
    t_vec2_partial();
    t_zero_threads();
    t_clamp();
    t_vec4_steal();
    t_busy_ignore();
    t_back_to_back();
    t_idle();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule